// File: doc/BRIEF.md
# Translation Lookaside Buffer with Walker Refill

This block is the address translation cache of a memory management unit. A lookup brings a 32-bit virtual address plus two mode bits (user or supervisor, read or write). Pages are 4 KB. The upper 20 address bits form the page number and are compared against every stored line at once. The low 12 bits pass through unchanged. A hit answers on the next cycle with the physical address, or with a fault when the stored permissions forbid the access. No table access is made on a hit.

On a miss the block stops taking lookups and asks an external page-table walker for the missing page number. When the walker answers, the block checks the returned entry against the pending access. A good entry goes into one line and the access completes. A walker answer of "absent", or an entry that forbids the access, ends the lookup as a fault and stores nothing. The victim line is the lowest-numbered invalid line if there is one; otherwise it is a round-robin pointer that steps on every install. A flush input clears every line in one cycle.

The lookup port uses valid/ready. Hold `req_valid` and the request fields until `req_ready` is high at a clock edge. `req_ready` is low from the edge that accepts a miss until the edge that completes it. The response is a one-cycle pulse with no back-pressure, so the consumer must take it. The walker request uses valid/ready and is held stable until accepted. The walker answer is a single-cycle `walk_rsp_valid` pulse; it counts only while a walk is waiting for it.

Top module: `mmu_tlb`

## Requirements
- R1: The physical address is {page frame, req_vaddr[11:0]}; the 12 offset bits are never altered.
- R2: A lookup accepted at an edge whose page is held in a valid line gives rsp_valid high after that same edge, and no walker request is raised.
- R3: A lookup that misses raises walk_req_valid after its accept edge, with walk_req_vpn = req_vaddr[31:12]; both are held stable until walk_req_ready is high at an edge.
- R4: After the walker answer is taken at an edge, rsp_valid pulses after that edge with the refilled frame. If no fault occurred, the entry is installed and a later access to the same page hits.
- R5: walk_rsp_attr is {present, readable, writable, user_ok} (bit 3 down to bit 0). An access faults when readable is 0, when it is a write and writable is 0, or when it comes from user mode and user_ok is 0. The check runs on hits and on refills alike.
- R6: A walker answer with present = 0, or an answer whose permissions fault the pending access, raises rsp_fault and installs nothing, so the next access to that page misses again.
- R7: The victim is the lowest-indexed invalid line. When every line is valid, it is the line at a round-robin pointer. The pointer starts at 0 after reset and advances by one (modulo ENTRIES) on every install.
- R8: A flush pulse clears all valid bits in one cycle, so every later lookup misses. An install in the same cycle still takes effect.
- R9: req_ready is low from the accept edge of a miss until the edge that completes the refill, and is high otherwise.
- R10: On every faulting response, rsp_fault_vaddr holds the full virtual address of the faulting access.
- R11: After reset, no line is valid, req_ready is high, and walk_req_valid and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted (low = busy with refill) |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user-mode access |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Lookup result pulse |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Access faulted |
| rsp_fault_vaddr | output | 32 | Virtual address of the last faulting access |
| walk_req_valid | output | 1 | Refill request to the walker |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | 20 | Page number to be walked |
| walk_rsp_valid | input | 1 | Walker answer pulse |
| walk_rsp_pfn | input | 20 | Returned page frame |
| walk_rsp_attr | input | 4 | {present, readable, writable, user_ok} |

## Verification
The bench covers these corner cases:
- A refused refill, either an absent page or a permission violation, must be followed by a second miss on the same page. A design that installed on a fault would hit there instead.
- The same page is checked under each mode combination. A design with a swapped permission field would fault the wrong access.
- A walker that delays its ready checks that the request stays held. Lookups issued while a refill is outstanding check that req_ready stays low.
- After a flush, the bench fills every line and then forces one eviction. It checks that exactly the line named by the install count is lost. A design that ignored invalid lines, or stepped the pointer only on some installs, would lose a different page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = 20;
  localparam int PA_W  = PFN_W + OFF_W;

  typedef struct packed {
    logic rd;
    logic wr;
    logic usr;
  } perm_t;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    perm_t            perm;
  } tlb_line_t;

  function automatic logic perm_fault(perm_t p, logic user, logic write);
    return !p.rd || (write && !p.wr) || (user && !p.usr);
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tlb_line_t        lines   [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  input  logic [VPN_W-1:0] vpn,
  output logic             hit,
  output tlb_line_t        hit_line
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (lines[g].vpn == vpn);
  end

  always_comb begin
    hit_line = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_line = hit_line | lines[i];
  end

  assign hit = |match;

  // R4: refills only install missing pages, so at most one line matches
  p_unique_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic               install,
  output logic [IDX_W-1:0]   victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim = any_free ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_q <= '0;
    else if (install) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  // R7: a valid line is never chosen while an invalid one exists
  p_invalid_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid) |-> !valid[victim]);
endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_user,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [VA_W-1:0]  rsp_fault_vaddr,
  output logic             walk_req_valid,
  input  logic             walk_req_ready,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             walk_rsp_valid,
  input  logic [PFN_W-1:0] walk_rsp_pfn,
  input  logic [3:0]       walk_rsp_attr
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} state_t;

  state_t             state_q;
  tlb_line_t          lines_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [VA_W-1:0]    pend_va_q;
  logic               pend_user_q, pend_write_q;

  logic               hit;
  tlb_line_t          hit_line;
  logic [IDX_W-1:0]   victim;
  perm_t              new_perm;
  logic               hit_fault, refill_fault, refill_done, install, accept;

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .clk(clk), .rst_n(rst_n), .lines(lines_q), .valid(valid_q),
    .vpn(req_vaddr[VA_W-1:OFF_W]), .hit(hit), .hit_line(hit_line));

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .install(install),
    .victim(victim));

  assign new_perm     = '{rd: walk_rsp_attr[2], wr: walk_rsp_attr[1], usr: walk_rsp_attr[0]};
  assign accept       = (state_q == S_IDLE) && req_valid;
  assign hit_fault    = perm_fault(hit_line.perm, req_user, req_write);
  assign refill_done  = (state_q == S_RSP) && walk_rsp_valid;
  assign refill_fault = !walk_rsp_attr[3] || perm_fault(new_perm, pend_user_q, pend_write_q);
  assign install      = refill_done && !refill_fault;

  assign req_ready      = (state_q == S_IDLE);
  assign walk_req_valid = (state_q == S_REQ);
  assign walk_req_vpn   = pend_va_q[VA_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q         <= S_IDLE;
      valid_q         <= '0;
      pend_va_q       <= '0;
      pend_user_q     <= 1'b0;
      pend_write_q    <= 1'b0;
      rsp_valid       <= 1'b0;
      rsp_paddr       <= '0;
      rsp_fault       <= 1'b0;
      rsp_fault_vaddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (flush) valid_q <= '0;
      case (state_q)
        S_IDLE: if (accept) begin
          pend_va_q    <= req_vaddr;
          pend_user_q  <= req_user;
          pend_write_q <= req_write;
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_fault <= hit_fault;
            rsp_paddr <= {hit_line.pfn, req_vaddr[OFF_W-1:0]};
            if (hit_fault) rsp_fault_vaddr <= req_vaddr;
          end else begin
            state_q <= S_REQ;
          end
        end
        S_REQ: if (walk_req_ready) state_q <= S_RSP;
        S_RSP: if (walk_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_fault <= refill_fault;
          rsp_paddr <= {walk_rsp_pfn, pend_va_q[OFF_W-1:0]};
          if (refill_fault) rsp_fault_vaddr <= pend_va_q;
          else              valid_q[victim] <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (install)
      lines_q[victim] <= '{vpn: pend_va_q[VA_W-1:OFF_W], pfn: walk_rsp_pfn, perm: new_perm};
  end

  // R2: a hit never starts a walk
  p_hit_no_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> !walk_req_valid);
  // R3: walker request held until taken
  p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=> (walk_req_valid && $stable(walk_req_vpn)));
  // R6: a refused refill leaves the valid bits alone
  p_fault_no_install_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_done && refill_fault && !flush) |=> $stable(valid_q));
  // R8: flush empties the buffer
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !install) |=> (valid_q == '0));
  // R9: a missing lookup makes the block busy
  p_miss_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> !req_ready);
endmodule

// File: tb/mmu_tlb_tb_top.sv
module mmu_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 32;

  typedef struct packed {
    logic [31:0] va;
    logic        user;
    logic        write;
    logic [19:0] pfn;
    logic [3:0]  attr;
    logic        miss;
    logic        fault;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1234, 1'b0, 1'b0, 20'hABCDE, 4'hF, 1'b1, 1'b0},
    '{32'h0000_1FFF, 1'b1, 1'b1, 20'hABCDE, 4'hF, 1'b0, 1'b0},
    '{32'h0000_2000, 1'b1, 1'b0, 20'h12345, 4'hE, 1'b1, 1'b1},
    '{32'h0000_2000, 1'b0, 1'b0, 20'h12345, 4'hE, 1'b1, 1'b0},
    '{32'h0000_2010, 1'b1, 1'b0, 20'h12345, 4'hE, 1'b0, 1'b1},
    '{32'h0000_3000, 1'b0, 1'b1, 20'h0BEEF, 4'hD, 1'b1, 1'b1},
    '{32'h0000_3004, 1'b1, 1'b0, 20'h0BEEF, 4'hD, 1'b1, 1'b0},
    '{32'h0000_3008, 1'b1, 1'b1, 20'h0BEEF, 4'hD, 1'b0, 1'b1},
    '{32'h0000_3ABC, 1'b0, 1'b0, 20'h0BEEF, 4'hD, 1'b0, 1'b0},
    '{32'h0000_4000, 1'b0, 1'b0, 20'h00444, 4'h8, 1'b1, 1'b1},
    '{32'h0000_5000, 1'b0, 1'b0, 20'h00555, 4'h7, 1'b1, 1'b1},
    '{32'h0000_5004, 1'b0, 1'b0, 20'h00555, 4'hF, 1'b1, 1'b0},
    '{32'hFFFF_F00C, 1'b1, 1'b1, 20'hFFFFF, 4'hF, 1'b1, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic        req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault, walk_req_valid;
  logic [31:0] rsp_paddr, rsp_fault_vaddr;
  logic [19:0] walk_req_vpn;
  logic        walk_req_ready = 1'b0, walk_rsp_valid = 1'b0;
  logic [19:0] walk_rsp_pfn = '0;
  logic [3:0]  walk_rsp_attr = '0;

  int checks = 0, failures = 0, installs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_tlb #(.ENTRIES(ENTRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_user(req_user), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_fault_vaddr(rsp_fault_vaddr),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
    .walk_req_vpn(walk_req_vpn), .walk_rsp_valid(walk_rsp_valid),
    .walk_rsp_pfn(walk_rsp_pfn), .walk_rsp_attr(walk_rsp_attr));

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] va, input logic u, input logic w,
                        input logic [19:0] pfn, input logic [3:0] attr, input int dly,
                        output logic miss, output logic flt,
                        output logic [31:0] pa, output logic [31:0] fva);
    @(negedge clk);
    chk(req_ready, "R9", "ready before lookup", 64'(req_ready), 1);
    req_valid = 1'b1; req_vaddr = va; req_user = u; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    miss = 1'b0;
    if (!rsp_valid && walk_req_valid) begin
      miss = 1'b1;
      chk(!req_ready, "R9", "busy during refill", 64'(req_ready), 0);
      chk(walk_req_vpn == va[31:12], "R3", "walk vpn", 64'(walk_req_vpn), 64'(va[31:12]));
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk(walk_req_valid && walk_req_vpn == va[31:12], "R3", "request held",
            64'(walk_req_vpn), 64'(va[31:12]));
      end
      walk_req_ready = 1'b1;
      @(negedge clk);
      walk_req_ready = 1'b0;
      walk_rsp_valid = 1'b1; walk_rsp_pfn = pfn; walk_rsp_attr = attr;
      @(negedge clk);
      walk_rsp_valid = 1'b0;
    end
    chk(rsp_valid, "R4", "response pulse", 64'(rsp_valid), 1);
    flt = rsp_fault; pa = rsp_paddr; fva = rsp_fault_vaddr;
  endtask

  task automatic expect_access(input logic [31:0] va, input logic [19:0] pfn,
                               input logic exp_miss, input string rq);
    logic m, f;
    logic [31:0] pa, fv;
    access(va, 1'b0, 1'b0, pfn, 4'hF, 0, m, f, pa, fv);
    chk(m == exp_miss, rq, "miss flag", 64'(m), 64'(exp_miss));
    chk(!f && pa == {pfn, va[11:0]}, rq, "paddr", 64'(pa), 64'({pfn, va[11:0]}));
    if (m) installs++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic m, f;
    logic [31:0] pa, fv;
    int rr;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(req_ready && !walk_req_valid && !rsp_valid, "R11", "reset outputs",
        64'({req_ready, walk_req_valid, rsp_valid}), 64'h4);
    rst_n = 1'b1;

    // Vector table: R1, R2, R4, R5, R6, R10
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].va, VECS[i].user, VECS[i].write, VECS[i].pfn, VECS[i].attr,
             (i == 0) ? 2 : 0, m, f, pa, fv);
      chk(m == VECS[i].miss, VECS[i].miss ? "R6" : "R2", "miss flag", 64'(m), 64'(VECS[i].miss));
      chk(f == VECS[i].fault, "R5", "fault flag", 64'(f), 64'(VECS[i].fault));
      if (VECS[i].fault)
        chk(fv == VECS[i].va, "R10", "fault vaddr", 64'(fv), 64'(VECS[i].va));
      else
        chk(pa == {VECS[i].pfn, VECS[i].va[11:0]}, "R1", "paddr", 64'(pa),
            64'({VECS[i].pfn, VECS[i].va[11:0]}));
      if (VECS[i].miss && !VECS[i].fault) installs++;
    end

    // R8: flush empties every line
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    expect_access(32'h0000_1234, 20'hABCDE, 1'b1, "R8");

    // R7: refill after flush fills in index order, then round robin
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      expect_access({20'h00100 + 20'(i), 12'h040}, 20'h40000 + 20'(i), 1'b1, "R7");
    for (int i = 0; i < ENTRIES; i++)
      expect_access({20'h00100 + 20'(i), 12'h080}, 20'h40000 + 20'(i), 1'b0, "R7");
    rr = installs % ENTRIES;
    expect_access(32'h0020_0000, 20'h77777, 1'b1, "R7");
    expect_access({20'h00100 + 20'(rr), 12'h000}, 20'h40000 + 20'(rr), 1'b1, "R7");
    expect_access({20'h00100 + 20'((rr + 2) % ENTRIES), 12'h000},
                  20'h40000 + 20'((rr + 2) % ENTRIES), 1'b0, "R7");
    expect_access(32'h0020_0ABC, 20'h77777, 1'b0, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule